// File: doc/BRIEF.md
# Victim Line Buffer for a Direct-Mapped Cache

This block is a small, fully associative store that sits next to a direct-mapped data cache. It holds the lines the cache has just pushed out. When the cache misses, it presents the wanted line address here. Every entry compares its stored tag against that address at the same time. On a match the block returns the line in the same cycle, and the cache's outgoing line takes that entry's place. No memory access is made. When nothing matches, the request is passed on to the next level down. If the cache is pushing out a line in that cycle, that line is stored in the buffer.

Each entry holds one full line, a valid bit and a tag equal to the complete line address (cache tag plus index), because an entry does not belong to any set. Only lines the cache discards are ever written. A request that misses here does not allocate an entry. A flush input invalidates every entry.

An occupancy state machine with three states steers allocation. The states are OCC_EMPTY (no valid entry), OCC_PARTIAL (some entries valid) and OCC_FULL (all entries valid). The transitions are as follows:
- Storing a line moves OCC_EMPTY to OCC_PARTIAL, or to OCC_FULL when there is only one entry.
- Filling the last free entry moves OCC_PARTIAL to OCC_FULL.
- A hit with no line coming back frees an entry. This moves OCC_FULL to OCC_PARTIAL, or moves OCC_PARTIAL to OCC_EMPTY when it was the last valid entry.
- A flush moves any state to OCC_EMPTY.

In OCC_EMPTY and OCC_PARTIAL, an incoming line goes to the free entry with the lowest index. In OCC_FULL it overwrites the entry named by a round-robin replacement pointer, which keeps first-in, first-out order.

Top module: `victim_cache`

## Requirements
- R1: After reset no entry is valid: any request reports `hit_o` = 0 and `miss_fwd_o` = 1. The replacement pointer starts at entry 0.
- R2: When `req_valid_i` = 1 and a valid entry's tag equals `req_addr_i`, `hit_o` = 1 and `hit_data_o` carries that entry's line in the same cycle, with `miss_fwd_o` = 0. Otherwise `hit_data_o` = 0.
- R3: When `req_valid_i` = 1 and no valid entry matches, `miss_fwd_o` = 1 and `miss_addr_o` = `req_addr_i` in the same cycle, with `hit_o` = 0. When `req_valid_i` = 0, `hit_o`, `miss_fwd_o` and `miss_addr_o` are all 0.
- R4: A request that misses while `evict_valid_i` = 0 allocates nothing, so a later request for the same address misses again.
- R5: A line stored while at least one entry is invalid goes into the lowest-indexed invalid entry. No valid entry is disturbed.
- R6: A line stored while all entries are valid overwrites the entry at the replacement pointer. The pointer then advances by one and wraps from the last entry to 0. It moves only on such a replacement, and returns to 0 on a flush.
- R7: On a hit with `evict_valid_i` = 1, the evicted address and line are written into the hit entry at the clock edge. Afterwards the hit address misses, and the evicted address hits and returns the evicted line.
- R8: On a hit with `evict_valid_i` = 0, the hit entry becomes invalid at the clock edge. The next stored line fills that entry and no older entry is lost.
- R9: `flush_i` = 1 invalidates all entries at the clock edge and takes priority over any write in that cycle. A request in the flush cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate all entries at the next edge |
| req_valid_i | input | 1 | Primary-miss lookup request present |
| req_addr_i | input | ADDR_W | Line address looked up |
| evict_valid_i | input | 1 | The cache is pushing out a line this cycle |
| evict_addr_i | input | ADDR_W | Full line address of the outgoing line |
| evict_data_i | input | LINE_W | Data of the outgoing line |
| hit_o | output | 1 | Lookup matched a valid entry |
| hit_data_o | output | LINE_W | Line returned on a hit, 0 otherwise |
| miss_fwd_o | output | 1 | Lookup forwarded to the next level |
| miss_addr_o | output | ADDR_W | Forwarded line address, 0 when not forwarding |

## Verification
A corrupted valid bit or tag shows up at the next request for the affected address. Such a request returns a hit where a miss is due, or forwards a line the buffer should have returned. A wrong replacement pointer or a wrong free-entry choice drops the wrong older line. That error only appears when the surviving lines are requested again, so the bench requests every live address after each structural event. A swap written to the wrong entry shows up one cycle later: the evicted address misses, or another entry's data changes.

// File: rtl/victim_pkg.sv
package victim_pkg;

    typedef enum logic [1:0] {
        OCC_EMPTY   = 2'd0,
        OCC_PARTIAL = 2'd1,
        OCC_FULL    = 2'd2
    } occ_e;

endpackage

// File: rtl/vc_match.sv
module vc_match #(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12
) (
    input  logic [ENTRIES-1:0]             valid_i,
    input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
    input  logic [ADDR_W-1:0]              addr_i,
    output logic [ENTRIES-1:0]             match_o
);

    // One comparator per entry, all evaluated in parallel.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match_o[g] = valid_i[g] && (tag_i[g] == addr_i);
    end

endmodule

// File: rtl/vc_alloc.sv
module vc_alloc #(
    parameter int ENTRIES = 4,
    parameter int IDX_W   = 2
) (
    input  logic [ENTRIES-1:0] valid_i,
    input  logic [IDX_W-1:0]   ptr_i,
    input  logic               full_i,
    output logic [IDX_W-1:0]   slot_o
);

    logic [IDX_W-1:0] free_idx;

    // Lowest-indexed invalid entry wins.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_i[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign slot_o = full_i ? ptr_i : free_idx;

endmodule

// File: rtl/victim_cache.sv
module victim_cache
    import victim_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 12,
    parameter int LINE_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic              evict_valid_i,
    input  logic [ADDR_W-1:0] evict_addr_i,
    input  logic [LINE_W-1:0] evict_data_i,
    output logic              hit_o,
    output logic [LINE_W-1:0] hit_data_o,
    output logic              miss_fwd_o,
    output logic [ADDR_W-1:0] miss_addr_o
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0]             valid_q, valid_d;
    logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
    logic [ENTRIES-1:0][LINE_W-1:0] data_q;
    logic [IDX_W-1:0]               ptr_q, ptr_d;
    occ_e                           state_q, state_d;

    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   alloc_idx;
    logic [IDX_W-1:0]   wr_idx;
    logic               any_match;
    logic               buf_full;
    logic               do_swap, do_take, do_ins, wr_en;
    logic [CNT_W-1:0]   cnt_d;

    vc_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_match (
        .valid_i (valid_q),
        .tag_i   (tag_q),
        .addr_i  (req_addr_i),
        .match_o (match)
    );

    vc_alloc #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_alloc (
        .valid_i (valid_q),
        .ptr_i   (ptr_q),
        .full_i  (buf_full),
        .slot_o  (alloc_idx)
    );

    // Hit index and data mux
    always_comb begin
        hit_idx    = '0;
        hit_data_o = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx    = IDX_W'(i);
                hit_data_o = hit_data_o | data_q[i];
            end
        end
        if (!req_valid_i) begin
            hit_data_o = '0;
        end
    end

    assign any_match   = |match;
    assign hit_o       = req_valid_i && any_match;
    assign miss_fwd_o  = req_valid_i && !any_match;
    assign miss_addr_o = miss_fwd_o ? req_addr_i : '0;

    // Outputs of the occupancy state machine
    always_comb begin
        buf_full = 1'b0;
        unique case (state_q)
            OCC_EMPTY:   buf_full = 1'b0;
            OCC_PARTIAL: buf_full = 1'b0;
            OCC_FULL:    buf_full = 1'b1;
            default:     buf_full = 1'b0;
        endcase
    end

    // Next-state of entries, pointer and occupancy
    always_comb begin
        do_swap = hit_o && evict_valid_i;
        do_take = hit_o && !evict_valid_i;
        do_ins  = !hit_o && evict_valid_i;
        wr_en   = (do_swap || do_ins) && !flush_i;
        wr_idx  = hit_o ? hit_idx : alloc_idx;

        valid_d = valid_q;
        ptr_d   = ptr_q;
        if (flush_i) begin
            valid_d = '0;
            ptr_d   = '0;
        end else begin
            if (wr_en) begin
                valid_d[wr_idx] = 1'b1;
            end else if (do_take) begin
                valid_d[hit_idx] = 1'b0;
            end
            if (do_ins && buf_full) begin
                ptr_d = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
            end
        end

        cnt_d = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            cnt_d = cnt_d + CNT_W'(valid_d[i]);
        end
        if (cnt_d == '0) begin
            state_d = OCC_EMPTY;
        end else if (cnt_d == CNT_W'(ENTRIES)) begin
            state_d = OCC_FULL;
        end else begin
            state_d = OCC_PARTIAL;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OCC_EMPTY;
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            valid_q <= valid_d;
            ptr_q   <= ptr_d;
        end
    end

    // Line storage
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= evict_addr_i;
            data_q[wr_idx] <= evict_data_i;
        end
    end

    // R3
    hit_or_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |-> (hit_o ^ miss_fwd_o));

    // R2
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_q == '0 && state_q == OCC_EMPTY && ptr_q == '0));

    // R6
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_FULL) == ($countones(valid_q) == ENTRIES));

    // R5
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OCC_EMPTY) == (valid_q == '0));

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !(do_ins && buf_full)) |=> $stable(ptr_q));

    // R8
    take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_take && !flush_i) |=> !valid_q[$past(hit_idx)]);

endmodule

// File: tb/victim_cache_tb.sv
module victim_cache_tb;

    localparam int ENT    = 4;
    localparam int ADDR_W = 12;
    localparam int LINE_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush_i = 1'b0;
    logic              req_valid_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic              evict_valid_i = 1'b0;
    logic [ADDR_W-1:0] evict_addr_i = '0;
    logic [LINE_W-1:0] evict_data_i = '0;
    logic              hit_o;
    logic [LINE_W-1:0] hit_data_o;
    logic              miss_fwd_o;
    logic [ADDR_W-1:0] miss_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    // Reference model state
    bit                mv [ENT];
    logic [ADDR_W-1:0] mt [ENT];
    logic [LINE_W-1:0] md [ENT];
    int                mp;

    always #10 clk = ~clk;

    victim_cache #(.ENTRIES(ENT), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .flush_i       (flush_i),
        .req_valid_i   (req_valid_i),
        .req_addr_i    (req_addr_i),
        .evict_valid_i (evict_valid_i),
        .evict_addr_i  (evict_addr_i),
        .evict_data_i  (evict_data_i),
        .hit_o         (hit_o),
        .hit_data_o    (hit_data_o),
        .miss_fwd_o    (miss_fwd_o),
        .miss_addr_o   (miss_addr_o)
    );

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int model_find(input logic [ADDR_W-1:0] a);
        for (int i = 0; i < ENT; i++) begin
            if (mv[i] && mt[i] == a) return i;
        end
        return -1;
    endfunction

    task automatic model_clear();
        for (int i = 0; i < ENT; i++) mv[i] = 0;
        mp = 0;
    endtask

    // One cycle: drive at negedge, compare before posedge, advance model.
    task automatic step(input logic rv, input logic [ADDR_W-1:0] ra,
                        input logic ev, input logic [ADDR_W-1:0] ea,
                        input logic [LINE_W-1:0] ed, input logic fl,
                        input string tag);
        int h;
        int slot;
        @(negedge clk);
        req_valid_i   = rv;
        req_addr_i    = ra;
        evict_valid_i = ev;
        evict_addr_i  = ea;
        evict_data_i  = ed;
        flush_i       = fl;
        #5;
        h = rv ? model_find(ra) : -1;
        chk(tag, "hit_o",       64'(hit_o),      64'(h >= 0));
        chk(tag, "hit_data_o",  64'(hit_data_o), (h >= 0) ? 64'(md[h]) : 64'd0);
        chk(tag, "miss_fwd_o",  64'(miss_fwd_o), 64'(rv && h < 0));
        chk(tag, "miss_addr_o", 64'(miss_addr_o), (rv && h < 0) ? 64'(ra) : 64'd0);
        if (fl) begin
            model_clear();
        end else if (h >= 0) begin
            if (ev) begin
                mt[h] = ea;
                md[h] = ed;
            end else begin
                mv[h] = 0;
            end
        end else if (ev) begin
            slot = -1;
            for (int i = ENT - 1; i >= 0; i--) if (!mv[i]) slot = i;
            if (slot < 0) begin
                slot = mp;
                mp = (mp + 1) % ENT;
            end
            mv[slot] = 1;
            mt[slot] = ea;
            md[slot] = ed;
        end
    endtask

    task automatic look(input logic [ADDR_W-1:0] a, input string tag);
        step(1'b1, a, 1'b0, '0, '0, 1'b0, tag);
    endtask

    task automatic put(input logic [ADDR_W-1:0] a, input logic [LINE_W-1:0] d,
                       input string tag);
        step(1'b0, '0, 1'b1, a, d, 1'b0, tag);
    endtask

    // Watchdog
    initial begin
        #3000000;
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [ADDR_W-1:0] ra, ea;
        logic              rv, ev, fl;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(12'h123, "R1");
        look(12'h000, "R1");
        // R3: idle cycle drives nothing
        step(1'b0, 12'h055, 1'b0, '0, '0, 1'b0, "R3");

        // R4: miss without eviction allocates nothing
        look(12'h0A1, "R4");
        look(12'h0A1, "R4");

        // R5: fill entries 0..3 in order
        put(12'h101, 32'hAAAA0001, "R5");
        put(12'h202, 32'hAAAA0002, "R5");
        put(12'h303, 32'hAAAA0003, "R5");
        put(12'h404, 32'hAAAA0004, "R5");
        // R2: all four hit with their data
        look(12'h101, "R2");
        look(12'h202, "R2");
        look(12'h303, "R2");
        look(12'h404, "R2");
        look(12'h505, "R3");

        // R6: full, replace pointer entry 0 then entry 1
        put(12'h505, 32'hBBBB0005, "R6");
        look(12'h101, "R6");
        look(12'h202, "R6");
        look(12'h505, "R6");
        put(12'h606, 32'hBBBB0006, "R6");
        look(12'h202, "R6");
        look(12'h303, "R6");
        look(12'h606, "R6");

        // R7: swap on hit with eviction
        step(1'b1, 12'h303, 1'b1, 12'h707, 32'hCCCC0007, 1'b0, "R7");
        look(12'h303, "R7");
        look(12'h707, "R7");
        look(12'h404, "R7");

        // R8: hit without eviction frees entry, next line fills the hole
        look(12'h505, "R8");
        look(12'h505, "R8");
        put(12'h808, 32'hDDDD0008, "R8");
        look(12'h808, "R8");
        look(12'h606, "R8");
        look(12'h707, "R8");
        look(12'h404, "R8");

        // R9: flush, same-cycle lookup still sees old contents
        step(1'b1, 12'h404, 1'b1, 12'h909, 32'hEEEE0009, 1'b1, "R9");
        look(12'h404, "R9");
        look(12'h909, "R9");
        look(12'h606, "R9");
        // R6: pointer restarts at 0 after flush
        put(12'h011, 32'h11, "R6");
        put(12'h022, 32'h22, "R6");
        put(12'h033, 32'h33, "R6");
        put(12'h044, 32'h44, "R6");
        put(12'h055, 32'h55, "R6");
        look(12'h011, "R6");
        look(12'h022, "R6");

        // Mixed traffic over a small address set
        for (int n = 0; n < 3000; n++) begin
            rv = ($urandom % 4) != 0;
            ra = 12'($urandom % 12);
            ev = ($urandom % 3) != 0;
            fl = ($urandom % 80) == 0;
            ea = '0;
            if (ev) begin
                ev = 1'b0;
                for (int t = 0; t < 8 && !ev; t++) begin
                    ea = 12'($urandom % 12);
                    if (model_find(ea) < 0 && !(rv && ea == ra)) ev = 1'b1;
                end
                if (!ev) ea = '0;
            end
            step(rv, ra, ev, ea, $urandom, fl, "R2");
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule